// File: doc/BRIEF.md
# Synchronous Serial Transmit Shifter

This block drives one data line of a synchronous serial link. It takes its bit timing from a clock produced elsewhere and brought in on a neighbouring pin. The transmitted bit changes on each falling edge of that clock, so a receiver with an idle-low clock can sample on the rising edge. Words are written through a simple write port. A shift register is backed by a single holding word, and a flag reports when that holding word has been taken. This lets software keep a stream running with no gap between words.

A control word sets the word length and the operating style. Continuous operation chains words back to back. Start-stop operation sends each word as a separate unit, with one idle-low bit slot between words.

The first word is primed by writing it while the block is disabled. The shifter then loads that word on the first enabled cycle. Nothing reports when the shifter itself has run dry. The only status is the holding-word-empty flag.

Top module: `sync_tx_shifter`

## Requirements
- R1: While reset is asserted, or while `en` is low, the shifter is cleared, `sdo` is 0 and `buf_empty` is 0. Reset clears the holding word. Clearing the holding word on disable is covered by R9.
- R2: The word length is `cfg[CW-1:0]` plus one, where a value of 15 gives 16 bits. The length is latched when a word enters the shifter. Data bits above the word length are never sent, so a 32-bit value goes out as two 16-bit halves by writing the value and then the value shifted right by 16.
- R3: Bits leave least significant first. `sdo` changes only on the cycle after a falling edge of `sclk_in` is seen, one bit per falling edge. A rising edge of `sclk_in` leaves `sdo` unchanged.
- R4: A word written while `en` is low is held. On the first cycle with `en` high, that word enters the shifter, `sdo` shows its bit 0 and `buf_empty` rises.
- R5: A word written while the shifter is busy waits in the holding word. In continuous mode (`cfg[CW]`=0), it enters the shifter on the falling edge that ends the current word, with no gap. `buf_empty` rises in that same cycle.
- R6: In continuous mode, if the holding word is empty when a word ends, `sdo` keeps the last bit sent. A later write enters the shifter one cycle after it is written.
- R7: In start-stop mode (`cfg[CW]`=1), `sdo` returns to 0 for one bit slot after each word ends. A waiting word, or a word written while the shifter is idle, enters the shifter only on a falling edge of `sclk_in`. Priming at enable is the exception, as stated in R4.
- R8: Every write clears `buf_empty` on the next cycle, including a write made in the same cycle as a transfer.
- R9: A high-to-low change of `en` discards an unsent holding word. Enabling again afterwards starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | CW+1 | `[CW-1:0]` word length minus one, `[CW]` start-stop mode |
| en | input | 1 | Enable; low holds the output quiet and allows priming |
| wr | input | 1 | Write strobe for `wdata` |
| wdata | input | DW | Word to send, least significant bit first |
| sclk_in | input | 1 | Shift clock from the adjacent pin |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding word has moved into the shifter |

## Verification
The bench builds the block with its default 32-bit write port, which gives a 5-bit length field. This makes 4, 8, 16 and the full 32-bit word length all reachable, including the all-ones length value. With that width the bench can send one 32-bit value as two chained 16-bit halves and check the halves on the line in order. It also exercises underrun in continuous mode, the idle slot between start-stop words, and the discarding of a buffered word on disable.

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter #(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(DW):0]   cfg,
  input  logic                  en,
  input  logic                  wr,
  input  logic [DW-1:0]         wdata,
  input  logic                  sclk_in,
  output logic                  sdo,
  output logic                  buf_empty
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh, hold;
  logic [CW-1:0] left;
  logic          active, hold_v, sclk_q, en_q;

  wire stop = cfg[CW];
  wire fall = sclk_q & ~sclk_in;
  wire last = active & fall & (left == '0);
  wire take = en & hold_v &
              (active ? (last & ~stop) : (~stop | fall | ~en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; hold <= '0; left <= '0;
      active <= 1'b0; hold_v <= 1'b0; sdo <= 1'b0;
      buf_empty <= 1'b0; sclk_q <= 1'b0; en_q <= 1'b0;
    end else begin
      sclk_q <= sclk_in;
      en_q   <= en;
      if (!en) begin
        sh <= '0; left <= '0; active <= 1'b0;
        sdo <= 1'b0; buf_empty <= 1'b0;
        if (en_q) hold_v <= 1'b0;
      end else if (take) begin
        sdo       <= hold[0];
        sh        <= hold >> 1;
        left      <= cfg[CW-1:0];
        active    <= 1'b1;
        hold_v    <= 1'b0;
        buf_empty <= 1'b1;
      end else if (active && fall) begin
        if (left == '0) begin
          active <= 1'b0;
          if (stop) sdo <= 1'b0;
        end else begin
          sdo  <= sh[0];
          sh   <= sh >> 1;
          left <= left - 1'b1;
        end
      end
      if (wr) begin
        hold      <= wdata;
        hold_v    <= 1'b1;
        buf_empty <= 1'b0;
      end
    end
  end

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sdo && !buf_empty));
  a_r3_moves_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !fall) |=> $stable(sdo));
  a_r5_flag_with_busy_shifter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> active);
  a_r6_underrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stop && last && !hold_v) |=> $stable(sdo));
  a_r7_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop && last) |=> !sdo);
  a_r8_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !buf_empty);
endmodule

// File: tb/tb_sync_tx_shifter.sv
module tb_sync_tx_shifter;
  localparam int DW = 32;
  localparam int CW = $clog2(DW);

  logic clk = 0, rst_n = 0, en = 0, wr = 0, sclk = 0;
  logic [CW:0] cfg = '0;
  logic [DW-1:0] wdata = '0;
  logic sdo, buf_empty;

  int errors = 0, checks = 0, cyc = 0;
  string req = "R1";
  bit rx_on = 0;
  bit rx_bits [0:63];
  int rx_n = 0;

  sync_tx_shifter #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .wr(wr),
    .wdata(wdata), .sclk_in(sclk), .sdo(sdo), .buf_empty(buf_empty));

  always #2 clk = ~clk;

  // behavioural reference
  logic [DW-1:0] m_q[$];
  logic [DW-1:0] m_word;
  int  m_pos, m_len;
  bit  m_busy, m_out, m_flag, m_prev, m_enq, m_fall, m_done, m_was, m_stop;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_out = 0; m_flag = 0; m_prev = 0; m_enq = 0; m_q.delete();
    end else begin
      m_fall = m_prev && !sclk;
      m_prev = sclk;
      m_stop = cfg[CW];
      if (!en) begin
        m_busy = 0; m_out = 0; m_flag = 0;
        if (m_enq) m_q.delete();
      end else begin
        m_was  = m_busy;
        m_done = m_busy && m_fall && (m_pos == m_len - 1);
        if (m_busy && m_fall && !m_done) begin
          m_pos++;
          m_out = m_word[m_pos];
        end
        if (m_done) begin
          m_busy = 0;
          if (m_stop) m_out = 0;
        end
        if (m_q.size() > 0 &&
            ((m_done && !m_stop) || (!m_was && (!m_stop || m_fall || !m_enq)))) begin
          m_word = m_q.pop_front();
          m_pos = 0; m_len = int'(cfg[CW-1:0]) + 1;
          m_busy = 1; m_out = m_word[0]; m_flag = 1;
        end
      end
      if (wr) begin
        m_q.delete(); m_q.push_back(wdata);
        if (en) m_flag = 0;
      end
      m_enq = en;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sdo !== m_out || buf_empty !== m_flag) begin
        errors++;
        $display("FAIL %s cycle %0d: sdo/buf_empty actual %b/%b expected %b/%b",
                 req, cyc, sdo, buf_empty, m_out, m_flag);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1;
      if (rx_on && rx_n < 64) begin rx_bits[rx_n] = sdo; rx_n++; end
      repeat (half - 1) @(negedge clk);
      @(negedge clk); sclk = 0;
      repeat (half - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_rx(input int first, input int len, input logic [DW-1:0] exp, input string r);
    logic [DW-1:0] got = '0;
    for (int i = 0; i < len; i++) got[i] = rx_bits[first + i];
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s received word: actual %h expected %h", r, got, exp);
    end
  endtask

  task automatic check_out(input logic s, input logic f, input string r);
    checks++;
    if (sdo !== s || buf_empty !== f) begin
      errors++;
      $display("FAIL %s direct: sdo/buf_empty actual %b/%b expected %b/%b",
               r, sdo, buf_empty, s, f);
    end
  endtask

  initial begin
    idle(3);
    check_out(0, 0, "R1");
    @(negedge clk); rst_n = 1;
    idle(2);
    check_out(0, 0, "R1");

    // R4 prime, R5 chaining, R2 8-bit length, R3 LSB first
    req = "R4"; cfg = 6'd7;
    write_word(32'hFFFF_FFA5);
    idle(2);
    @(negedge clk); en = 1;
    @(negedge clk);
    check_out(1, 1, "R4");
    req = "R8";
    write_word(32'h0000_003C);
    check_out(1, 0, "R8");
    req = "R5"; rx_n = 0; rx_on = 1;
    pulses(16, 2);
    rx_on = 0;
    check_rx(0, 8, 32'hA5, "R3");
    check_rx(8, 8, 32'h3C, "R5");
    req = "R6";
    pulses(4, 3);
    check_out(0, 1, "R6");
    write_word(32'h81);
    idle(2);
    pulses(8, 2);

    // R2 two 16-bit halves
    req = "R2"; cfg = 6'd15; rx_n = 0;
    write_word(32'hDEAD_BEEF);
    write_word(32'hDEAD_BEEF >> 16);
    rx_on = 1;
    pulses(32, 2);
    rx_on = 0;
    check_rx(0, 16, 32'hBEEF, "R2");
    check_rx(16, 16, 32'hDEAD, "R2");

    // R7 start-stop, 4-bit words
    req = "R7"; cfg = 6'd32 | 6'd3;
    write_word(32'h5);
    pulses(2, 2);
    write_word(32'hA);
    pulses(14, 2);
    check_out(0, 1, "R7");

    // full 32-bit continuous word
    req = "R2"; cfg = 6'd31;
    write_word(32'h8000_0001);
    pulses(34, 1);

    // R9 disable discards a buffered word
    req = "R9"; cfg = 6'd32 | 6'd7;
    write_word(32'h77);
    idle(3);
    @(negedge clk); en = 0;
    idle(2);
    @(negedge clk); en = 1;
    idle(3);
    pulses(3, 2);
    check_out(0, 0, "R9");

    // R1 reset mid-word
    req = "R1"; cfg = 6'd7;
    write_word(32'hF0);
    pulses(5, 2);
    @(negedge clk); rst_n = 0;
    idle(2);
    check_out(0, 0, "R1");
    @(negedge clk); rst_n = 1;
    pulses(4, 2);
    check_out(0, 0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule